// File: doc/BRIEF.md
# Sparse-Tree Prefix Adder

This block adds two unsigned operands and a carry-in, and returns the sum and a carry-out. Underneath it is a parallel prefix adder in which the carry tree resolves group carries only at odd bit positions. A single extra merge level then fills in the even positions from their odd neighbours. The tree starts with one level that pairs adjacent bits. It continues with doubling-distance levels over the odd positions only, and ends with the merge level. An operand width of `W` therefore takes `log2(W)+1` prefix levels, which is 5 levels at the default width of 16.

The carry-in is handled as the generate of an imaginary position below bit 0 whose propagate is zero. It is folded into bit 0 before the tree. Every prefix group that reaches down to bit 0 is therefore fully resolved, and those cells are reduced to generate-only cells. The result can leave the block straight from the logic, or through a reset-cleared output register that adds one cycle of latency for timing closure.

Top module: `hc_prefix_adder`

## Requirements
- R1: `{cout, sum}` equals the `W+1`-bit value `a + b + cin` for every operand pair and carry-in.
- R2: With both operands zero, `sum` equals the carry-in, zero-extended, and `cout` is 0.
- R3: When every bit position propagates (`a ^ b` all ones) and `cin` is 1, the carry ripples through the whole word: `sum` is 0 and `cout` is 1.
- R4: With `REG_OUT = 1`, an active-low `rst_n` clears `sum` and `cout` to 0, whatever the operands are.
- R5: With `REG_OUT = 1`, a result appears on the outputs one clock edge after its operands are sampled; until that edge the previous result holds. With `REG_OUT = 0`, the outputs follow the inputs with no clock.
- R6: `cout` is 1 exactly when `a + b + cin` is at least `2**W`. All ones plus all ones plus 1 gives `cout = 1` with a sum of all ones.
- R7: Exchanging `a` and `b` leaves `sum` and `cout` unchanged.
- R8: `W` must be a power of two and at least 4; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
In the default registered build, a sum is due one rising edge after its operands are applied. The bench therefore drives operands on a falling edge and compares the result on the next falling edge, against a value it computed with plain integer addition when it applied those operands. One check drives new operands and then looks before the next rising edge, to confirm that the old result is still held. A second, unregistered 4-bit instance is swept over all 512 input combinations and compared one time unit after each change, with no clock involved.

// File: rtl/hc_prefix_adder.sv
module hc_prefix_adder #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LOG = $clog2(W);
  localparam int LV  = LOG + 1;

  if ((W < 4) || ((1 << LOG) != W)) begin : g_bad_width
    $error("hc_prefix_adder: W must be a power of two, at least 4"); // R8
  end

  logic [W-1:0] p0;
  logic [W-1:0] gl [0:LV];
  logic [W-1:0] pl [0:LV];
  logic [W-1:0] cy;
  logic [W-1:0] sum_c;
  logic         cout_c;
  logic         unused_pl;

  assign p0     = a ^ b;
  assign gl[0]  = {a[W-1:1] & b[W-1:1], (a[0] & b[0]) | (p0[0] & cin)};
  assign pl[0]  = {p0[W-1:1], 1'b0};

  for (genvar lv = 0; lv <= LOG; lv++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam int D    = (lv == 0 || lv == LOG) ? 1 : (1 << lv);
      localparam bit ACT  = (lv == 0)   ? (i % 2 == 1) :
                            (lv == LOG) ? (i % 2 == 0 && i >= 2) :
                                          (i % 2 == 1 && i >= D);
      localparam bit GREY = (lv == LOG) || ((i - D) < D);
      if (ACT) begin : g_cell
        assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i-D]);
        if (GREY) begin : g_grey
          assign pl[lv+1][i] = 1'b0;
        end else begin : g_black
          assign pl[lv+1][i] = pl[lv][i] & pl[lv][i-D];
        end
      end else begin : g_pass
        assign gl[lv+1][i] = gl[lv][i];
        assign pl[lv+1][i] = pl[lv][i];
      end
    end
  end

  assign unused_pl = ^pl[LV];
  assign cy        = gl[LV];
  assign sum_c     = p0 ^ {cy[W-2:0], cin};
  assign cout_c    = cy[W-1];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_c;
        cout <= cout_c;
      end
    end

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + (W+1)'($past(cin))))); // R1
    AST_CIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (a == '0 && b == '0) |=> (!cout && sum == W'($past(cin)))); // R2
    AST_FULL_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((a ^ b) == '1 && cin) |=> (cout && sum == '0)); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (sum == '0 && !cout)); // R4
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = cout_c;

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |-> ({cout, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)))); // R1
    AST_CIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (a == '0 && b == '0) |-> (!cout && sum == W'(cin))); // R2
    AST_FULL_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((a ^ b) == '1 && cin) |-> (cout && sum == '0)); // R3
  end
endmodule

// File: tb/hc_prefix_adder_bench.sv
module hc_prefix_adder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  logic [3:0]  as = '0, bs = '0;
  logic        cs = 1'b0;
  logic [3:0]  sums;
  logic        couts;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [16:0] pend_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  hc_prefix_adder #(.W(16), .REG_OUT(1'b1)) u_hc_prefix_adder (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  hc_prefix_adder #(.W(4), .REG_OUT(1'b0)) u_small (
    .clk(clk), .rst_n(rst_n), .a(as), .b(bs), .cin(cs), .sum(sums), .cout(couts));

  function automatic logic [16:0] model(input logic [15:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + 17'(c);
  endfunction

  task automatic check(input logic [16:0] act, exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic flush();
    if (pend_q.size() != 0) check({cout, sum}, pend_q.pop_front(), tag_q.pop_front());
  endtask

  task automatic drive(input logic [15:0] x, y, input logic c, input string tag);
    @(negedge clk);
    flush();
    a = x; b = y; cin = c;
    pend_q.push_back(model(x, y, c));
    tag_q.push_back(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [16:0] prev;
    a = 16'hffff; b = 16'h0001; cin = 1'b1;
    repeat (3) @(negedge clk);
    check({cout, sum}, 17'h0, "R4 reset clears outputs");
    @(negedge clk); rst_n = 1'b1;
    a = '0; b = '0; cin = 1'b0;

    drive(16'h0000, 16'h0000, 1'b1, "R2 cin only set");
    drive(16'h0000, 16'h0000, 1'b0, "R2 cin only clear");
    drive(16'h5555, 16'haaaa, 1'b1, "R3 full ripple alternating");
    drive(16'hffff, 16'h0000, 1'b1, "R3 full ripple ones");
    drive(16'hffff, 16'hffff, 1'b1, "R6 max overflow");
    drive(16'h8000, 16'h8000, 1'b0, "R6 top bit overflow");
    drive(16'h7fff, 16'h0000, 1'b1, "R6 just below overflow");
    drive(16'h00ff, 16'h0f01, 1'b0, "R1 mixed");
    for (int k = 0; k < 1500; k++) begin
      logic [15:0] x, y;
      logic c;
      x = 16'($urandom); y = 16'($urandom); c = 1'($urandom);
      drive(x, y, c, "R1 R6 random");
      drive(y, x, c, "R7 swapped operands");
    end
    @(negedge clk);
    flush();

    prev = {cout, sum};
    a = 16'd100; b = 16'd23; cin = 1'b0;
    #1 check({cout, sum}, prev, "R5 result held before edge");
    @(negedge clk);
    check({cout, sum}, 17'd123, "R5 result after one edge");

    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      as = i[3:0]; bs = i[7:4]; cs = i[8];
      #1 check({12'h0, couts, sums}, {12'h0, 5'({1'b0, as} + {1'b0, bs} + 5'(cs))},
               "R1 R5 exhaustive 4-bit combinational");
    end

    @(negedge clk); rst_n = 1'b0; a = 16'h1234; b = 16'h4321;
    #1 check({cout, sum}, 17'h0, "R4 async reset mid-run");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule